// File: doc/BRIEF.md
# Host-Fed Blit Data Packer

This block runs a block transfer whose source pixels come from the host CPU rather than from video memory. Once a host-source transfer is started, every byte the host writes into the frame-buffer aperture is taken by the block and does not reach the normal frame-buffer write path. The block collects those bytes into 32-bit words. It expands each complete word into pixels and sends every pixel through a raster operation against the current destination byte. It then writes the result to destination memory.

The block keeps a pixel count and a line count and compares them with inclusive width and height values. A host word may reach past the end of a line, and the pixels past the end are dropped. At the end of each line the destination pointer moves down by one pitch. When the last line is done, the block drops its busy status and forwards host writes again. While a word is being expanded, the host byte port is held off with a ready signal, so no byte is lost.

Top module: `host_blit_packer`

## Requirements
- R1: A transfer starts when `ctl_wr` is high with `ctl_data[1]` set while `cfg_mode[2]` is set and no transfer is active. From the next cycle `blt_status` reads 2'b11. A start request with `cfg_mode[2]` clear, or one made while a transfer is active, has no effect.
- R2: While a transfer is active, host byte writes are not forwarded: `fb_wr_en` stays low. While idle, `fb_wr_en`, `fb_wr_addr` and `fb_wr_data` follow `hw_valid`, `hw_addr` and `hw_data` in the same cycle.
- R3: Host bytes are packed little-endian. Byte n of a group of four (n = 0..3) lands in word bits 8n+7..8n, and the fourth byte completes the word.
- R4: In colour-expand mode (`cfg_mode[7]` set), a word gives 32 pixels, taken from bit 0 up to bit 31. A set bit gives `cfg_fg` and a clear bit gives `cfg_bg`.
- R5: In byte mode (`cfg_mode[7]` clear), a word gives four pixels, taken from bits 7..0 first and bits 31..24 last.
- R6: A pixel is written only while the pixel count is at most `cfg_width`. Dropped pixels still advance the destination pointer and the pixel count.
- R7: After a word, if the pixel count exceeds `cfg_width`, the pixel count clears and the line count increments. The next pixel goes to `cfg_dst_base + cfg_dst_pitch * line`.
- R8: When the line count exceeds `cfg_height`, the transfer ends. `blt_status` returns to 2'b00, no further memory accesses occur, and host writes are forwarded again.
- R9: `hw_ready` is low from the cycle after a word completes until that word has been fully expanded. Bytes offered during that time are held, not lost.
- R10: The raster operation code gives the result from source S and destination D: 0x00 gives 0x00, 0x0B gives ~D, 0x0D gives S, 0x0E gives 0xFF, 0x05 gives S&D, 0x6D gives S|D, 0x59 gives S^D. Any other code leaves D unchanged.
- R11: Each written pixel is preceded by a read of the same address in the previous cycle. Read data returns one cycle after `mem_rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_mode | input | 8 | Mode byte; bit 2 selects host source, bit 7 selects colour expand |
| cfg_rop | input | 8 | Raster operation code |
| cfg_fg | input | 8 | Foreground colour for colour expand |
| cfg_bg | input | 8 | Background colour for colour expand |
| cfg_width | input | DIM_W | Last pixel index of a line (inclusive) |
| cfg_height | input | DIM_W | Last line index (inclusive) |
| cfg_dst_base | input | ADDR_W | Destination start address |
| cfg_dst_pitch | input | ADDR_W | Destination line pitch in bytes |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_data | input | 8 | Control write data; bit 1 requests start |
| hw_valid | input | 1 | Host byte write valid |
| hw_addr | input | ADDR_W | Host write address |
| hw_data | input | 8 | Host write byte |
| hw_ready | output | 1 | Host write accepted |
| fb_wr_en | output | 1 | Forwarded frame-buffer write strobe |
| fb_wr_addr | output | ADDR_W | Forwarded write address |
| fb_wr_data | output | 8 | Forwarded write byte |
| mem_rd_en | output | 1 | Destination read request |
| mem_rd_addr | output | ADDR_W | Destination read address |
| mem_rd_data | input | 8 | Destination read data, one cycle latency |
| mem_wr_en | output | 1 | Destination write strobe |
| mem_wr_addr | output | ADDR_W | Destination write address |
| mem_wr_data | output | 8 | Destination write byte |
| blt_status | output | 2 | Bit 0 transfer in progress, bit 1 started; both clear on completion |

## Verification
A byte counter out of step would put the colours of a whole word in the wrong positions. That shows as a data mismatch on the first write after the bad word. A pixel or line counter that is off by one shows at the end of the first line: either an extra write where a pixel should have been dropped, or a write to the wrong line address. The scoreboard flags it at that write. A stuck phase shows within a few cycles as `hw_ready` staying low or `blt_status` never clearing. Expected writes are predicted from the mode, colours, geometry and each host word. They are compared in order with every destination write.

// File: rtl/hfb_pkg.sv
package hfb_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_WAIT  = 2'd1,
        PH_READ  = 2'd2,
        PH_WRITE = 2'd3
    } phase_e;

    localparam int MODE_HOST_BIT   = 2;
    localparam int MODE_EXPAND_BIT = 7;
    localparam int CTL_START_BIT   = 1;

    localparam logic [7:0] ROP_ZERO  = 8'h00;
    localparam logic [7:0] ROP_NDST  = 8'h0B;
    localparam logic [7:0] ROP_SRC   = 8'h0D;
    localparam logic [7:0] ROP_ONES  = 8'h0E;
    localparam logic [7:0] ROP_AND   = 8'h05;
    localparam logic [7:0] ROP_OR    = 8'h6D;
    localparam logic [7:0] ROP_XOR   = 8'h59;

endpackage

// File: rtl/hfb_rop.sv
module hfb_rop
    import hfb_pkg::*;
(
    input  logic [7:0] rop,
    input  logic [7:0] src,
    input  logic [7:0] dst,
    output logic [7:0] res
);
    always_comb begin
        unique case (rop)
            ROP_ZERO: res = 8'h00;
            ROP_NDST: res = ~dst;
            ROP_SRC:  res = src;
            ROP_ONES: res = 8'hFF;
            ROP_AND:  res = src & dst;
            ROP_OR:   res = src | dst;
            ROP_XOR:  res = src ^ dst;
            default:  res = dst;
        endcase
    end
endmodule

// File: rtl/hfb_packer.sv
module hfb_packer (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        capture,
    input  logic        take_ok,
    input  logic        hw_valid,
    input  logic [7:0]  hw_data,
    output logic        pk_ready,
    output logic        word_valid,
    output logic [31:0] word_data
);
    typedef struct packed {
        logic [1:0]  cnt;
        logic [23:0] held;
    } pk_t;

    pk_t st_d, st_q;
    logic accept;

    assign pk_ready = capture & take_ok;
    assign accept   = hw_valid & pk_ready;

    always_comb begin
        st_d       = st_q;
        word_valid = 1'b0;
        word_data  = {hw_data, st_q.held};
        if (clr) begin
            st_d.cnt  = 2'd0;
            st_d.held = '0;
        end else if (accept) begin
            if (st_q.cnt == 2'd3) begin
                word_valid = 1'b1;
                st_d.cnt   = 2'd0;
            end else begin
                st_d.held[{st_q.cnt, 3'b000} +: 8] = hw_data;
                st_d.cnt = st_q.cnt + 2'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_HOLD_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && !take_ok && !clr) |=> $stable(st_q.cnt)); // R9
endmodule

// File: rtl/hfb_expander.sv
module hfb_expander
    import hfb_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DIM_W  = 12,
    localparam int CNT_W = DIM_W + 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cfg_expand,
    input  logic [7:0]        cfg_rop,
    input  logic [7:0]        cfg_fg,
    input  logic [7:0]        cfg_bg,
    input  logic [DIM_W-1:0]  cfg_width,
    input  logic [DIM_W-1:0]  cfg_height,
    input  logic [ADDR_W-1:0] cfg_dst_base,
    input  logic [ADDR_W-1:0] cfg_dst_pitch,
    input  logic              word_valid,
    input  logic [31:0]       word_data,
    input  logic [7:0]        mem_rd_data,
    output logic              active,
    output logic              take_ok,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [7:0]        mem_wr_data
);
    typedef struct packed {
        phase_e             ph;
        logic [31:0]        word;
        logic [4:0]         idx;
        logic [CNT_W-1:0]   pix;
        logic [CNT_W-1:0]   line;
        logic [ADDR_W-1:0]  dst;
        logic [ADDR_W-1:0]  lbase;
        logic [ADDR_W-1:0]  pitch;
        logic               ce;
        logic [7:0]         rop;
        logic [7:0]         fg;
        logic [7:0]         bg;
        logic [CNT_W-1:0]   width;
        logic [CNT_W-1:0]   height;
    } ex_t;

    ex_t st_d, st_q;
    logic [7:0]       src_pix;
    logic             keep;
    logic             adv;
    logic [4:0]       last_idx;
    logic [CNT_W-1:0] pix_n;
    logic [CNT_W-1:0] line_n;
    logic [ADDR_W-1:0] lbase_n;

    assign active      = (st_q.ph != PH_IDLE);
    assign take_ok     = (st_q.ph == PH_WAIT);
    assign mem_rd_addr = st_q.dst;
    assign mem_wr_addr = st_q.dst;
    assign keep        = (st_q.pix <= st_q.width);
    assign last_idx    = st_q.ce ? 5'd31 : 5'd3;

    always_comb begin
        if (st_q.ce) src_pix = st_q.word[st_q.idx] ? st_q.fg : st_q.bg;
        else         src_pix = st_q.word[{st_q.idx[1:0], 3'b000} +: 8];
    end

    hfb_rop u_rop (
        .rop (st_q.rop),
        .src (src_pix),
        .dst (mem_rd_data),
        .res (mem_wr_data)
    );

    always_comb begin
        st_d      = st_q;
        mem_rd_en = 1'b0;
        mem_wr_en = 1'b0;
        adv       = 1'b0;
        pix_n     = st_q.pix + 1'b1;
        line_n    = st_q.line + 1'b1;
        lbase_n   = st_q.lbase + st_q.pitch;

        unique case (st_q.ph)
            PH_IDLE: begin
                if (start) begin
                    st_d.ph     = PH_WAIT;
                    st_d.pix    = '0;
                    st_d.line   = '0;
                    st_d.idx    = '0;
                    st_d.dst    = cfg_dst_base;
                    st_d.lbase  = cfg_dst_base;
                    st_d.pitch  = cfg_dst_pitch;
                    st_d.ce     = cfg_expand;
                    st_d.rop    = cfg_rop;
                    st_d.fg     = cfg_fg;
                    st_d.bg     = cfg_bg;
                    st_d.width  = CNT_W'(cfg_width);
                    st_d.height = CNT_W'(cfg_height);
                end
            end
            PH_WAIT: begin
                if (word_valid) begin
                    st_d.word = word_data;
                    st_d.idx  = '0;
                    st_d.ph   = PH_READ;
                end
            end
            PH_READ: begin
                if (keep) begin
                    mem_rd_en = 1'b1;
                    st_d.ph   = PH_WRITE;
                end else begin
                    adv = 1'b1;
                end
            end
            PH_WRITE: begin
                mem_wr_en = 1'b1;
                adv       = 1'b1;
            end
            default: st_d.ph = PH_IDLE;
        endcase

        if (adv) begin
            st_d.pix = pix_n;
            st_d.dst = st_q.dst + 1'b1;
            if (st_q.idx == last_idx) begin
                st_d.ph = PH_WAIT;
                if (pix_n > st_q.width) begin
                    st_d.pix   = '0;
                    st_d.line  = line_n;
                    st_d.lbase = lbase_n;
                    st_d.dst   = lbase_n;
                    if (line_n > st_q.height) st_d.ph = PH_IDLE;
                end
            end else begin
                st_d.idx = st_q.idx + 5'd1;
                st_d.ph  = PH_READ;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_WR_FOLLOWS_RD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> ($past(mem_rd_en) && mem_wr_addr == $past(mem_rd_addr))); // R11
    AST_WR_WITHIN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> (st_q.pix <= st_q.width)); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (!mem_rd_en && !mem_wr_en)); // R8
    AST_END_PAST_HEIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active) |-> (st_q.line > st_q.height)); // R8
    AST_WAIT_PIX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        take_ok |-> (st_q.pix <= st_q.width + CNT_W'(32))); // R7
endmodule

// File: rtl/host_blit_packer.sv
module host_blit_packer
    import hfb_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DIM_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        cfg_mode,
    input  logic [7:0]        cfg_rop,
    input  logic [7:0]        cfg_fg,
    input  logic [7:0]        cfg_bg,
    input  logic [DIM_W-1:0]  cfg_width,
    input  logic [DIM_W-1:0]  cfg_height,
    input  logic [ADDR_W-1:0] cfg_dst_base,
    input  logic [ADDR_W-1:0] cfg_dst_pitch,
    input  logic              ctl_wr,
    input  logic [7:0]        ctl_data,
    input  logic              hw_valid,
    input  logic [ADDR_W-1:0] hw_addr,
    input  logic [7:0]        hw_data,
    output logic              hw_ready,
    output logic              fb_wr_en,
    output logic [ADDR_W-1:0] fb_wr_addr,
    output logic [7:0]        fb_wr_data,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [7:0]        mem_rd_data,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [7:0]        mem_wr_data,
    output logic [1:0]        blt_status
);
    logic        active;
    logic        take_ok;
    logic        start_req;
    logic        start_go;
    logic        pk_ready;
    logic        word_valid;
    logic [31:0] word_data;
    logic        unused_bits;

    assign unused_bits = ^{cfg_mode[6:3], cfg_mode[1:0], ctl_data[7:2], ctl_data[0]};

    assign start_req  = ctl_wr & ctl_data[CTL_START_BIT] & cfg_mode[MODE_HOST_BIT];
    assign start_go   = start_req & ~active;
    assign hw_ready   = active ? pk_ready : 1'b1;
    assign fb_wr_en   = hw_valid & ~active;
    assign fb_wr_addr = hw_addr;
    assign fb_wr_data = hw_data;
    assign blt_status = {active, active};

    hfb_packer u_packer (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (start_go),
        .capture    (active),
        .take_ok    (take_ok),
        .hw_valid   (hw_valid),
        .hw_data    (hw_data),
        .pk_ready   (pk_ready),
        .word_valid (word_valid),
        .word_data  (word_data)
    );

    hfb_expander #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) u_expander (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start_go),
        .cfg_expand    (cfg_mode[MODE_EXPAND_BIT]),
        .cfg_rop       (cfg_rop),
        .cfg_fg        (cfg_fg),
        .cfg_bg        (cfg_bg),
        .cfg_width     (cfg_width),
        .cfg_height    (cfg_height),
        .cfg_dst_base  (cfg_dst_base),
        .cfg_dst_pitch (cfg_dst_pitch),
        .word_valid    (word_valid),
        .word_data     (word_data),
        .mem_rd_data   (mem_rd_data),
        .active        (active),
        .take_ok       (take_ok),
        .mem_rd_en     (mem_rd_en),
        .mem_rd_addr   (mem_rd_addr),
        .mem_wr_en     (mem_wr_en),
        .mem_wr_addr   (mem_wr_addr),
        .mem_wr_data   (mem_wr_data)
    );

    AST_START_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req && blt_status == 2'b00) |=> (blt_status == 2'b11)); // R1
    AST_HOLD_WHILE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !take_ok) |-> !hw_ready); // R9
endmodule

// File: tb/host_blit_packer_bench.sv
module host_blit_packer_bench;
    localparam int ADDR_W = 24;
    localparam int DIM_W  = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [7:0]        cfg_mode = 8'h00, cfg_rop = 8'h0D, cfg_fg = 8'h00, cfg_bg = 8'h00;
    logic [DIM_W-1:0]  cfg_width = '0, cfg_height = '0;
    logic [ADDR_W-1:0] cfg_dst_base = '0, cfg_dst_pitch = '0;
    logic              ctl_wr = 1'b0;
    logic [7:0]        ctl_data = 8'h00;
    logic              hw_valid = 1'b0;
    logic [ADDR_W-1:0] hw_addr = '0;
    logic [7:0]        hw_data = 8'h00;
    logic              hw_ready, fb_wr_en, mem_rd_en, mem_wr_en;
    logic [ADDR_W-1:0] fb_wr_addr, mem_rd_addr, mem_wr_addr;
    logic [7:0]        fb_wr_data, mem_wr_data;
    logic [7:0]        mem_rd_data = 8'h00;
    logic [1:0]        blt_status;

    always #2.5 clk = ~clk;

    host_blit_packer #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) u_host_blit_packer (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_rop(cfg_rop),
        .cfg_fg(cfg_fg), .cfg_bg(cfg_bg), .cfg_width(cfg_width), .cfg_height(cfg_height),
        .cfg_dst_base(cfg_dst_base), .cfg_dst_pitch(cfg_dst_pitch),
        .ctl_wr(ctl_wr), .ctl_data(ctl_data), .hw_valid(hw_valid), .hw_addr(hw_addr),
        .hw_data(hw_data), .hw_ready(hw_ready), .fb_wr_en(fb_wr_en),
        .fb_wr_addr(fb_wr_addr), .fb_wr_data(fb_wr_data), .mem_rd_en(mem_rd_en),
        .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data), .mem_wr_en(mem_wr_en),
        .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data), .blt_status(blt_status)
    );

    // destination memory model, one cycle read latency
    logic [7:0] vram [256];
    logic [7:0] shadow [256];
    initial begin
        for (int i = 0; i < 256; i++) begin
            vram[i]   = 8'(i) ^ 8'h5A;
            shadow[i] = 8'(i) ^ 8'h5A;
        end
    end
    always @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= vram[mem_rd_addr[7:0]];
        if (mem_wr_en) vram[mem_wr_addr[7:0]] <= mem_wr_data;
    end

    typedef struct {
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
        string             tag;
    } exp_t;
    exp_t exp_q[$];

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string tag, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && mem_wr_en) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R6 unexpected write", longint'(mem_wr_addr), 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(mem_wr_addr == e.addr, {e.tag, " addr"}, longint'(mem_wr_addr), longint'(e.addr));
                check(mem_wr_data == e.data, {e.tag, " data"}, longint'(mem_wr_data), longint'(e.data));
            end
        end
    end

    // reference model state
    int unsigned m_pix, m_line, m_lbase, m_dst, m_w, m_h, m_pitch;
    bit m_ce;
    logic [7:0] m_rop, m_fg, m_bg;

    function automatic logic [7:0] ref_rop(input logic [7:0] r, input logic [7:0] s, input logic [7:0] d);
        case (r)
            8'h00: return 8'h00;
            8'h0B: return ~d;
            8'h0D: return s;
            8'h0E: return 8'hFF;
            8'h05: return s & d;
            8'h6D: return s | d;
            8'h59: return s ^ d;
            default: return d;
        endcase
    endfunction

    task automatic model_word(input logic [31:0] w, input string tag);
        int n;
        n = m_ce ? 32 : 4;
        for (int k = 0; k < n; k++) begin
            logic [7:0] s;
            if (m_ce) s = w[k] ? m_fg : m_bg;
            else      s = w[8*k +: 8];
            if (m_pix <= m_w) begin
                exp_t e;
                e.addr = ADDR_W'(m_dst);
                e.data = ref_rop(m_rop, s, shadow[m_dst[7:0]]);
                e.tag  = tag;
                shadow[m_dst[7:0]] = e.data;
                exp_q.push_back(e);
            end
            m_dst++;
            m_pix++;
        end
        if (m_pix > m_w) begin
            m_pix = 0;
            m_line++;
            m_lbase += m_pitch;
            m_dst = m_lbase;
        end
    endtask

    task automatic start_blit(input logic [7:0] mode, input logic [7:0] rop,
                              input int w, input int h, input int base, input int pitch,
                              input logic [7:0] fg, input logic [7:0] bg);
        @(negedge clk);
        cfg_mode = mode; cfg_rop = rop; cfg_width = DIM_W'(w); cfg_height = DIM_W'(h);
        cfg_dst_base = ADDR_W'(base); cfg_dst_pitch = ADDR_W'(pitch); cfg_fg = fg; cfg_bg = bg;
        ctl_wr = 1'b1; ctl_data = 8'h02;
        @(posedge clk); #1;
        ctl_wr = 1'b0; ctl_data = 8'h00;
        m_pix = 0; m_line = 0; m_lbase = base; m_dst = base;
        m_w = w; m_h = h; m_pitch = pitch; m_ce = mode[7]; m_rop = rop; m_fg = fg; m_bg = bg;
    endtask

    task automatic put_byte(input logic [7:0] b, input logic [ADDR_W-1:0] a);
        @(negedge clk);
        hw_valid = 1'b1; hw_data = b; hw_addr = a;
        while (!hw_ready) @(negedge clk);
        @(posedge clk); #1;
        hw_valid = 1'b0;
    endtask

    task automatic put_word(input logic [31:0] w, input string tag);
        model_word(w, tag);
        for (int n = 0; n < 4; n++) begin
            put_byte(w[8*n +: 8], ADDR_W'(24'h000100 + n));
            if (n == 0) check(fb_wr_en == 1'b0, "R2 no forward while active", fb_wr_en, 0);
        end
        @(negedge clk);
        check(hw_ready == 1'b0, "R9 ready low while expanding", hw_ready, 0);
    endtask

    task automatic drain(input string tag);
        int t;
        t = 0;
        while ((exp_q.size() != 0 || blt_status != 2'b00) && t < 3000) begin
            @(negedge clk);
            t++;
        end
        check(exp_q.size() == 0, {tag, " all writes seen"}, exp_q.size(), 0);
        check(blt_status == 2'b00, {tag, " status clear at end"}, blt_status, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            fails++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(blt_status == 2'b00, "R1 reset status", blt_status, 0);
        check(mem_wr_en == 1'b0 && mem_rd_en == 1'b0, "R8 reset quiet", mem_wr_en, 0);

        // R1: start without host-source mode bit is ignored
        start_blit(8'h00, 8'h0D, 3, 0, 8'h10, 16, 8'h00, 8'h00);
        @(negedge clk);
        check(blt_status == 2'b00, "R1 no start without mode bit 2", blt_status, 0);

        // R5 R6 R7: byte mode, 6 pixels per line, two lines, two words per line
        start_blit(8'h04, 8'h0D, 5, 1, 8'h20, 16, 8'h00, 8'h00);
        @(negedge clk);
        check(blt_status == 2'b11, "R1 status after start", blt_status, 3);
        put_word(32'h03020100, "R5 byte order");
        // R1: a second start while active must be ignored
        @(negedge clk);
        cfg_dst_base = 24'h000090; ctl_wr = 1'b1; ctl_data = 8'h02;
        @(posedge clk); #1 ctl_wr = 1'b0;
        put_word(32'h07060504, "R6 line end drop");
        put_word(32'h13121110, "R7 second line address");
        put_word(32'h17161514, "R7 second line tail");
        drain("R8 byte mode");

        // R2: forwarding when idle
        @(negedge clk);
        hw_valid = 1'b1; hw_addr = 24'h001234; hw_data = 8'h77;
        #1;
        check(fb_wr_en == 1'b1 && fb_wr_addr == 24'h001234 && fb_wr_data == 8'h77,
              "R2 forward when idle", {fb_wr_en, fb_wr_data}, {1'b1, 8'h77});
        @(posedge clk); #1 hw_valid = 1'b0;

        // R4 R3: colour expand, 40 pixels, XOR
        start_blit(8'h84, 8'h59, 39, 0, 8'h80, 64, 8'hF0, 8'h0F);
        put_word(32'hA5A50F01, "R4 expand bit order");
        put_word(32'h000000FF, "R3 expand second word");
        drain("R8 expand");

        // R10: raster operations, one short line each
        begin
            logic [7:0] rops [6];
            rops[0] = 8'h00; rops[1] = 8'h0B; rops[2] = 8'h05;
            rops[3] = 8'h6D; rops[4] = 8'h0E; rops[5] = 8'h77;
            for (int r = 0; r < 6; r++) begin
                start_blit(8'h04, rops[r], 3, 0, 8'hC0 + 4 * r, 4, 8'h00, 8'h00);
                put_word(32'h44332211, "R10 rop");
                drain("R10 rop end");
            end
        end

        // R8: multi-line expand with heavy dropping, check final idle
        start_blit(8'h84, 8'h0D, 2, 2, 8'h40, 8, 8'hAA, 8'h55);
        put_word(32'h00000005, "R6 expand drop line0");
        put_word(32'h00000002, "R7 expand line1");
        put_word(32'h00000007, "R7 expand line2");
        drain("R8 three lines");
        @(negedge clk);
        check(hw_ready == 1'b1, "R8 ready after completion", hw_ready, 1);

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule